// File: doc/BRIEF.md
# Two-Wire Bus Master Clock and Condition Sequencer

This block is the bit-level engine of a two-wire (I2C style) bus master. It produces the serial clock and the START, repeated START and STOP conditions. It also places one data bit per command on the data line, or releases the line to read one. All timing comes from a shared tick whose period is a power of two of the module clock. Separate programmable tick counts set the clock-low time, the clock-high time, the start/stop spacing and the data setup/hold spacing.

The block never drives a line high. Its outputs are pull-low enables for SCL and SDA, and the real line levels come back through a two-flop synchroniser. Each low or high phase is counted from the moment the synchronised SCL is seen at that level, not from the moment the block pulls or releases it. A slave or a second master can therefore stretch the clock for as long as it likes, and the phase timing adjusts by itself.

A controller above this block issues one command at a time, waits for `busy` to drop and, after a bit, reads `rx_bit` when `bit_done` pulses. Byte framing, acknowledge handling and arbitration-loss handling belong to that controller.

Top module: `i2c_scl_sequencer`

## Requirements
- R1: After reset, both pull-low enables are 0, and `busy` and `bit_done` are 0.
- R2: One timing tick lasts 2^(cfg_exp+1) module clock cycles, and every counted phase of N ticks lasts N times that period. A count of 0 behaves as 1.
- R3: The SCL high time of a bit is cfg_high ticks, counted from when SCL is seen high. It is measured up to when the block pulls SCL low again, with at most 4 cycles of synchroniser overhead.
- R4: The SCL low time of a bit is (2*cfg_data + cfg_low) ticks, counted from acceptance of the bit command to the release of SCL.
- R5: For a write, SDA is pulled low exactly when tx_bit is 0 and released when it is 1. SDA changes only while SCL is held low, cfg_data ticks after the bit command is accepted.
- R6: For a read, SDA is released. rx_bit holds the SDA level sampled on the first tick after SCL is seen high. bit_done is a one-cycle pulse, given once SCL is low again, with busy already 0.
- R7: START from idle pulls SDA low while SCL is released, pulls SCL low after cfg_stasto ticks, and leaves the block not busy with both lines held low.
- R8: START while the bus is owned (repeated START) releases SDA while SCL is low, then releases SCL. SDA is pulled low cfg_stasto ticks after SCL is seen high, and SCL is pulled low cfg_stasto ticks after that.
- R9: STOP keeps SDA low through the SCL rise and releases it cfg_stasto ticks after SCL is seen high. busy drops a further cfg_stasto ticks later, with both lines released.
- R10: While SCL is held low by another device after the block releases it, the block waits without limit and does not pull SCL.
- R11: Commands are ignored while busy. On an idle bus only START has an effect, and write, read and STOP leave busy at 0 and both lines released.
- R12: Simultaneous commands on an owned bus resolve in the priority START, then STOP, then write, then read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_exp | input | EXP_W | Tick prescaler exponent; tick period 2^(cfg_exp+1) cycles |
| cfg_low | input | CNT_W | Ticks in the clock-low count |
| cfg_high | input | CNT_W | Ticks in the clock-high count |
| cfg_stasto | input | CNT_W | Ticks for START hold, repeated-START setup, STOP setup and bus-free time |
| cfg_data | input | CNT_W | Ticks for data hold and data setup |
| cmd_start | input | 1 | Strobe: START or repeated START |
| cmd_write | input | 1 | Strobe: send tx_bit |
| cmd_read | input | 1 | Strobe: receive one bit |
| cmd_stop | input | 1 | Strobe: STOP |
| tx_bit | input | 1 | Bit to send, taken with cmd_write |
| scl_in | input | 1 | Actual SCL line level |
| sda_in | input | 1 | Actual SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | An operation is in progress |
| bit_done | output | 1 | One-cycle pulse at the end of a bit |
| rx_bit | output | 1 | Sampled data bit |

## Verification
The assertions take for granted that other devices only ever hold SCL low while the block has it released and has not yet seen it high. No device pulls SCL during the block's own high count, and SDA stays steady while SCL is high outside START and STOP. The bench models the bus as a wired-AND of the block's enables with a clock-stretch flag and a slave data flag. It raises the stretch flag only while SCL is already low, drops it before the high phase, and changes the slave data only while SCL is held low between bits. Commands are one-cycle strobes, issued between clock edges.

// File: rtl/i2c_seq_pkg.sv
`timescale 1ns/1ps
package i2c_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HD_STA,
        ST_PULL,
        ST_HOLD,
        ST_DHOLD,
        ST_LOW,
        ST_SETUP,
        ST_WAITH,
        ST_HIGH,
        ST_SU_STA,
        ST_SU_STO,
        ST_BUF
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_BIT,
        OP_RSTART,
        OP_STOP
    } seq_op_e;

endpackage

// File: rtl/seq_line_sync.sv
`timescale 1ns/1ps
module seq_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '1;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/seq_tick_gen.sv
`timescale 1ns/1ps
module seq_tick_gen #(
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             tick
);

    localparam int PRE_W = 1 << EXP_W;
    localparam logic [EXP_W:0]   ONE_E = 1;
    localparam logic [PRE_W:0]   ONE_P = 1;
    localparam logic [PRE_W-1:0] INC   = 1;

    logic [PRE_W-1:0] cnt_d, cnt_q, mask;
    logic [PRE_W:0]   span, span_m1;

    always_comb begin
        span    = ONE_P << ({1'b0, exp_sel} + ONE_E);
        span_m1 = span - ONE_P;
        mask    = span_m1[PRE_W-1:0];
        tick    = (cnt_q == mask);
        cnt_d   = (clear || tick) ? '0 : cnt_q + INC;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/i2c_scl_sequencer.sv
`timescale 1ns/1ps
module i2c_scl_sequencer
    import i2c_seq_pkg::*;
#(
    parameter int EXP_W = 3,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXP_W-1:0] cfg_exp,
    input  logic [CNT_W-1:0] cfg_low,
    input  logic [CNT_W-1:0] cfg_high,
    input  logic [CNT_W-1:0] cfg_stasto,
    input  logic [CNT_W-1:0] cfg_data,
    input  logic             cmd_start,
    input  logic             cmd_write,
    input  logic             cmd_read,
    input  logic             cmd_stop,
    input  logic             tx_bit,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_drive_low,
    output logic             sda_drive_low,
    output logic             busy,
    output logic             bit_done,
    output logic             rx_bit
);

    localparam logic [CNT_W-1:0] CNT_INC = 1;
    localparam logic [CNT_W:0]   CNT_ONE = 1;

    typedef struct packed {
        seq_state_e       state;
        seq_op_e          op;
        logic [CNT_W-1:0] cnt;
        logic             sda_low;
        logic             tx_low;
        logic             rx;
        logic             bit_done;
    } seq_regs_t;

    seq_regs_t        r_d, r_q;
    logic [1:0]       line_s;
    logic             scl_s, sda_s;
    logic             tick, presc_clear, phase_done;
    logic [CNT_W-1:0] phase_n, limit;

    seq_line_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_in, sda_in}),
        .dout (line_s)
    );
    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    seq_tick_gen #(.EXP_W(EXP_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (presc_clear),
        .exp_sel(cfg_exp),
        .tick   (tick)
    );

    always_comb begin
        unique case (r_q.state)
            ST_HD_STA, ST_SU_STA, ST_SU_STO, ST_BUF: phase_n = cfg_stasto;
            ST_DHOLD, ST_SETUP:                      phase_n = cfg_data;
            ST_LOW:                                  phase_n = cfg_low;
            ST_HIGH:                                 phase_n = cfg_high;
            default:                                 phase_n = '0;
        endcase
        limit      = (phase_n == '0) ? CNT_INC : phase_n;
        phase_done = tick && (({1'b0, r_q.cnt} + CNT_ONE) >= {1'b0, limit});
    end

    always_comb begin
        r_d          = r_q;
        r_d.bit_done = 1'b0;
        if (tick) r_d.cnt = r_q.cnt + CNT_INC;

        unique case (r_q.state)
            ST_IDLE: begin
                if (cmd_start) begin
                    r_d.state   = ST_HD_STA;
                    r_d.op      = OP_RSTART;
                    r_d.sda_low = 1'b1;
                end
            end
            ST_HD_STA: if (phase_done) r_d.state = ST_PULL;
            ST_PULL: begin
                if (!scl_s) begin
                    r_d.state    = ST_HOLD;
                    r_d.bit_done = (r_q.op == OP_BIT);
                end
            end
            ST_HOLD: begin
                if (cmd_start) begin
                    r_d.state = ST_DHOLD;
                    r_d.op    = OP_RSTART;
                end else if (cmd_stop) begin
                    r_d.state = ST_DHOLD;
                    r_d.op    = OP_STOP;
                end else if (cmd_write || cmd_read) begin
                    r_d.state  = ST_DHOLD;
                    r_d.op     = OP_BIT;
                    r_d.tx_low = cmd_write && !tx_bit;
                end
            end
            ST_DHOLD: begin
                if (phase_done) begin
                    r_d.state = ST_LOW;
                    unique case (r_q.op)
                        OP_STOP:   r_d.sda_low = 1'b1;
                        OP_RSTART: r_d.sda_low = 1'b0;
                        default:   r_d.sda_low = r_q.tx_low;
                    endcase
                end
            end
            ST_LOW:   if (phase_done) r_d.state = ST_SETUP;
            ST_SETUP: if (phase_done) r_d.state = ST_WAITH;
            ST_WAITH: begin
                if (scl_s) begin
                    unique case (r_q.op)
                        OP_STOP:   r_d.state = ST_SU_STO;
                        OP_RSTART: r_d.state = ST_SU_STA;
                        default:   r_d.state = ST_HIGH;
                    endcase
                end
            end
            ST_HIGH: begin
                if (tick && (r_q.cnt == '0)) r_d.rx = sda_s;
                if (phase_done) r_d.state = ST_PULL;
            end
            ST_SU_STA: begin
                if (phase_done) begin
                    r_d.state   = ST_HD_STA;
                    r_d.sda_low = 1'b1;
                end
            end
            ST_SU_STO: begin
                if (phase_done) begin
                    r_d.state   = ST_BUF;
                    r_d.sda_low = 1'b0;
                end
            end
            ST_BUF:  if (phase_done) r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase

        presc_clear = (r_d.state != r_q.state);
        if (presc_clear) r_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, op: OP_RSTART, cnt: '0, sda_low: 1'b0,
                     tx_low: 1'b0, rx: 1'b0, bit_done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.state)
            ST_PULL, ST_HOLD, ST_DHOLD, ST_LOW, ST_SETUP: scl_drive_low = 1'b1;
            default:                                      scl_drive_low = 1'b0;
        endcase
    end

    assign sda_drive_low = r_q.sda_low;
    assign busy          = (r_q.state != ST_IDLE) && (r_q.state != ST_HOLD);
    assign bit_done      = r_q.bit_done;
    assign rx_bit        = r_q.rx;

endmodule

// File: rtl/i2c_scl_sequencer_chk.sv
`timescale 1ns/1ps
module i2c_scl_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_start,
    input logic cmd_write,
    input logic cmd_read,
    input logic cmd_stop,
    input logic scl_in,
    input logic scl_drive_low,
    input logic sda_drive_low,
    input logic busy,
    input logic bit_done
);

    logic bit_op_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_op_q <= 1'b0;
        end else if (!busy && scl_drive_low && (cmd_write || cmd_read)
                     && !cmd_start && !cmd_stop) begin
            bit_op_q <= 1'b1;
        end else if (bit_done) begin
            bit_op_q <= 1'b0;
        end
    end

    // R6
    bitdone_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_done |=> !bit_done);

    // R6
    bitdone_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_done |-> (scl_drive_low && !busy));

    // R5
    sda_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_op_q && !$stable(sda_drive_low)) |-> scl_drive_low);

    // R9
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !scl_drive_low) |-> !sda_drive_low);

    // R10
    stretch_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_drive_low && !scl_in) |=> !scl_drive_low);

    // R11
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !scl_drive_low && !cmd_start) |=> !busy);

endmodule

bind i2c_scl_sequencer i2c_scl_sequencer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_start    (cmd_start),
    .cmd_write    (cmd_write),
    .cmd_read     (cmd_read),
    .cmd_stop     (cmd_stop),
    .scl_in       (scl_in),
    .scl_drive_low(scl_drive_low),
    .sda_drive_low(sda_drive_low),
    .busy         (busy),
    .bit_done     (bit_done)
);

// File: tb/i2c_scl_sequencer_bench.sv
`timescale 1ns/1ps
module i2c_scl_sequencer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_exp = '0;
    logic [7:0] cfg_low = 8'd1, cfg_high = 8'd1, cfg_stasto = 8'd1, cfg_data = 8'd1;
    logic       cmd_start = 0, cmd_write = 0, cmd_read = 0, cmd_stop = 0, tx_bit = 0;
    logic       ext_scl_low = 0, slave_sda_low = 0;
    logic       scl_line, sda_line;
    logic       scl_drive_low, sda_drive_low, busy, bit_done, rx_bit;

    int n_checks = 0;
    int n_fail   = 0;
    int per, xlow, hi_t, st_t, dh_t;

    always #2 clk = ~clk;

    assign scl_line = !(scl_drive_low || ext_scl_low);
    assign sda_line = !(sda_drive_low || slave_sda_low);

    i2c_scl_sequencer u_i2c_scl_sequencer (
        .clk(clk), .rst_n(rst_n), .cfg_exp(cfg_exp), .cfg_low(cfg_low),
        .cfg_high(cfg_high), .cfg_stasto(cfg_stasto), .cfg_data(cfg_data),
        .cmd_start(cmd_start), .cmd_write(cmd_write), .cmd_read(cmd_read),
        .cmd_stop(cmd_stop), .tx_bit(tx_bit), .scl_in(scl_line), .sda_in(sda_line),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .busy(busy), .bit_done(bit_done), .rx_bit(rx_bit)
    );

    task automatic chk(input string req, input int act, input int lo, input int hi);
        n_checks++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic set_cfg(input int e, input int l, input int h, input int s, input int d);
        cfg_exp = e[2:0]; cfg_low = l[7:0]; cfg_high = h[7:0];
        cfg_stasto = s[7:0]; cfg_data = d[7:0];
        per  = 2 << e;
        xlow = (2 * d + l) * per;
        hi_t = h * per;
        st_t = s * per;
        dh_t = d * per;
    endtask

    task automatic strobe(input bit st, input bit wr, input bit rd, input bit sp, input bit val);
        @(negedge clk);
        cmd_start = st; cmd_write = wr; cmd_read = rd; cmd_stop = sp; tx_bit = val;
        @(posedge clk);
        #1;
        cmd_start = 0; cmd_write = 0; cmd_read = 0; cmd_stop = 0;
    endtask

    task automatic wait_free();
        for (int g = 0; g < 5000; g++) begin
            @(negedge clk);
            if (!busy) return;
        end
        chk("R1 busy never fell", 1, 0, 0);
    endtask

    // Waits until SCL is released after a bit-style low phase, returning the cycle count.
    task automatic wait_release(output int n);
        n = 0;
        for (int g = 0; g < 5000; g++) begin
            @(negedge clk);
            if (!scl_drive_low) return;
            n++;
        end
    endtask

    task automatic do_start();
        int n;
        n = 0;
        strobe(1, 0, 0, 0, 0);
        for (int g = 0; g < 5000; g++) begin
            @(negedge clk);
            if (n == 0) chk("R7 SDA low with SCL released", int'(sda_drive_low && scl_line), 1, 1);
            if (scl_drive_low) break;
            n++;
        end
        chk("R7 R2 start hold", n, st_t, st_t + 2);
        wait_free();
        chk("R7 both held after start", int'(scl_drive_low && sda_drive_low), 1, 1);
    endtask

    task automatic do_bit(input bit is_read, input bit val, input int stretch);
        int n, m, t_sda, g;
        bit prev_low;
        prev_low      = sda_drive_low;
        slave_sda_low = is_read && !val;
        ext_scl_low   = (stretch > 0);
        strobe(0, !is_read, is_read, 0, val);
        n = 0; t_sda = -1;
        for (g = 0; g < 5000; g++) begin
            @(negedge clk);
            if (!scl_drive_low) break;
            if (t_sda < 0 && prev_low && !sda_drive_low) t_sda = n;
            n++;
        end
        chk("R4 R2 low time", n, xlow, xlow + 2);
        if (prev_low && (is_read || val)) chk("R5 data hold", t_sda, dh_t, dh_t + 2);
        chk("R5 SDA level at SCL release", int'(sda_drive_low), int'(!is_read && !val),
            int'(!is_read && !val));
        if (stretch > 0) begin
            repeat (stretch) @(negedge clk);
            chk("R10 SCL not pulled while stretched", int'(scl_drive_low), 0, 0);
            ext_scl_low = 0;
        end
        m = 0;
        for (g = 0; g < 5000; g++) begin
            @(negedge clk);
            if (scl_drive_low) break;
            if (scl_line) m++;
        end
        chk("R3 R2 high time", m, hi_t, hi_t + 4);
        g = 0;
        while (!bit_done && g < 100) begin
            @(negedge clk);
            g++;
        end
        chk("R6 bit_done seen", int'(bit_done), 1, 1);
        chk("R6 rx_bit", int'(rx_bit), int'(val), int'(val));
        chk("R6 busy low at bit_done", int'(busy), 0, 0);
        @(negedge clk);
        chk("R6 bit_done one cycle", int'(bit_done), 0, 0);
        slave_sda_low = 0;
    endtask

    task automatic do_stop();
        int n, m, q;
        strobe(0, 0, 0, 1, 0);
        wait_release(n);
        chk("R9 SDA low at SCL rise", int'(sda_drive_low), 1, 1);
        m = 0;
        for (int g = 0; g < 5000 && sda_drive_low; g++) begin
            m++;
            @(negedge clk);
        end
        chk("R9 R2 stop setup", m, st_t, st_t + 4);
        chk("R9 SCL high at SDA release", int'(scl_line), 1, 1);
        q = 0;
        for (int g = 0; g < 5000 && busy; g++) begin
            q++;
            @(negedge clk);
        end
        chk("R9 bus free time", q, st_t, st_t + 2);
        chk("R9 lines released", int'(scl_drive_low || sda_drive_low), 0, 0);
    endtask

    task automatic do_rstart();
        int n, m, q;
        strobe(1, 0, 0, 0, 0);
        wait_release(n);
        chk("R8 SDA released before SCL", int'(sda_drive_low), 0, 0);
        m = 0;
        for (int g = 0; g < 5000 && !sda_drive_low; g++) begin
            m++;
            @(negedge clk);
        end
        chk("R8 restart setup", m, st_t, st_t + 4);
        chk("R8 SCL high at SDA fall", int'(scl_drive_low), 0, 0);
        q = 0;
        for (int g = 0; g < 5000 && !scl_drive_low; g++) begin
            q++;
            @(negedge clk);
        end
        chk("R8 restart hold", q, st_t, st_t + 2);
        wait_free();
        chk("R8 bus owned after restart", int'(scl_drive_low), 1, 1);
    endtask

    task automatic watch_quiet(input string req, input bit owned);
        int bad;
        bad = 0;
        repeat (20) begin
            @(negedge clk);
            if (busy || (scl_drive_low != owned) || (sda_drive_low != owned)) bad++;
        end
        chk(req, bad, 0, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", int'({scl_drive_low, sda_drive_low, busy, bit_done}), 0, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 outputs after reset", int'({scl_drive_low, sda_drive_low, busy, bit_done}), 0, 0);

        for (int e = 0; e < 3; e++)
            for (int h = 1; h <= 3; h++)
                for (int l = 1; l <= 2; l++)
                    for (int d = 1; d <= 2; d++) begin
                        set_cfg(e, l, h, h, d);
                        do_start();
                        do_bit(0, 1'b1, 0);
                        do_bit(1, bit'(d & 1), (l == 2) ? 5 : 0);
                        if (d == 2) do_rstart();
                        do_bit(0, bit'((h + l) & 1), 0);
                        do_stop();
                    end

        // R2: a zero count behaves as one tick
        set_cfg(1, 0, 1, 1, 1);
        xlow = 3 * per;
        do_start();
        do_bit(0, 1'b1, 0);
        do_stop();

        // R11: idle ignores everything but START
        set_cfg(0, 2, 2, 2, 1);
        strobe(0, 1, 0, 0, 1); watch_quiet("R11 write on idle bus", 0);
        strobe(0, 0, 1, 0, 0); watch_quiet("R11 read on idle bus", 0);
        strobe(0, 0, 0, 1, 0); watch_quiet("R11 stop on idle bus", 0);

        // R11: command while busy is dropped
        strobe(1, 0, 0, 0, 0);
        strobe(0, 1, 0, 0, 0);
        wait_free();
        watch_quiet("R11 write while busy ignored", 1);

        // R12: STOP wins over write
        strobe(0, 1, 0, 1, 0);
        wait_free();
        chk("R12 stop beats write", int'(scl_drive_low || sda_drive_low), 0, 0);

        // R12: START wins over STOP
        do_start();
        strobe(1, 0, 0, 1, 0);
        wait_free();
        chk("R12 start beats stop", int'(scl_drive_low), 1, 1);
        do_stop();

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule